// File: doc/BRIEF.md
# Mailbox FIFO register interface

This block is a byte mailbox between a host bus and an embedded controller. The host sees a small bank of 32-bit words through a single-cycle read/write strobe interface. Bytes the host writes go into a transmit queue that the controller drains over a valid/ready pair. Bytes the controller pushes go into a receive queue that the host drains by reading the data word. Each queue is eight bytes deep. In both directions the byte sits in bits 15:8 of the data word.

Four queue conditions are visible as live status bits. A rising edge on any condition latches an interrupt request bit. Each request has a mask bit, and the single interrupt output is raised while any request is set together with its mask. Requests are cleared by writing 1 to them, either in the interrupt word or in the status word. Writing back a status value that was just read therefore clears every latched flag it showed.

Each queue tracks its occupancy with a three-state machine:

| State | Meaning |
|---|---|
| `OCC_EMPTY` | the queue holds no bytes |
| `OCC_PART` | the queue holds some bytes but has free space |
| `OCC_FULL` | the queue holds DEPTH bytes |

| Transition | Condition |
|---|---|
| `OCC_EMPTY`→`OCC_PART` | an accepted push |
| `OCC_PART`→`OCC_FULL` | the count reaches DEPTH |
| `OCC_PART`→`OCC_EMPTY` | the count reaches zero |
| `OCC_FULL`→`OCC_PART` | an accepted pop |

Top module: `mbox_regif`

## Requirements
- R1: After reset both queues are empty, and the status word reads 0x3. The interrupt word reads 0, `irq_o` is 0, `ctl_tx_valid` is 0 and `ctl_rx_ready` is 1.
- R2: The word offsets are: interrupt word 0, data word 1, status word 2. Offsets 3 to 7 read as zero, and writes to them change nothing.
- R3: Status bits are:
  - bit 0: transmit queue empty
  - bit 1: transmit queue not full
  - bit 2: receive queue not empty
  - bit 3: receive overflow, which is sticky

  All higher bits read 0.
- R4: A host write to the data word queues `bus_wdata[15:8]`. The controller sees the queued bytes in write order on `ctl_tx_data` while `ctl_tx_valid` is 1. A byte is removed on each cycle with `ctl_tx_valid` and `ctl_tx_ready` both high.
- R5: The transmit queue holds 8 bytes. A host write while it is full is dropped.
- R6: A host read of the data word returns the oldest received byte in bits 15:8, with all other bits 0, and removes that byte. Bytes come back in push order.
- R7: A read of the data word while the receive queue is empty returns 0 and leaves the queue intact. The next pushed byte is the next byte read.
- R8: The receive queue holds 8 bytes, and `ctl_rx_ready` is 0 while it is full. A push with `ctl_rx_valid` while full discards the byte and sets status bit 3. Bit 3 stays set until 1 is written to status bit 3.
- R9: Interrupt word bits 3:0 are request flags in the same order as the status bits. Each sets one cycle after its condition rises and holds until 1 is written to that bit of the interrupt word or of the status word.
- R10: Interrupt word bits 7:4 are the mask bits for the same four conditions, loaded by every interrupt word write. `irq_o` is 1 exactly when some request bit and its mask bit are both 1.
- R11: A status word write clears every request bit and the sticky overflow bit that it writes with 1. Writing 1 to bit 2 alone acknowledges a received byte without touching the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| bus_sel | input | 1 | host access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | word offset |
| bus_wdata | input | 32 | host write data |
| bus_rdata | output | 32 | host read data, valid in the cycle of a read strobe |
| ctl_tx_data | output | 8 | oldest byte of the transmit queue |
| ctl_tx_valid | output | 1 | transmit queue holds a byte |
| ctl_tx_ready | input | 1 | controller takes the byte this cycle |
| ctl_rx_data | input | 8 | byte pushed by the controller |
| ctl_rx_valid | input | 1 | controller pushes a byte this cycle |
| ctl_rx_ready | output | 1 | receive queue has space |
| irq_o | output | 1 | masked interrupt request |

## Verification
The assertions assume one host access per strobe cycle, with `bus_addr` and `bus_wr` meaningful whenever `bus_sel` is high. They also assume the controller drives a push only when it intends one, and that a push with `ctl_rx_ready` low is a deliberate overflow. The stimulus keeps to these assumptions. It issues each host access or controller handshake alone and follows it with an idle cycle, so every edge-latched request has settled before the next read. Overflow is reached only by pushing into a queue whose ready output is already low.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int unsigned REG_INTR = 0;
    localparam int unsigned REG_DATA = 1;
    localparam int unsigned REG_STAT = 2;
    localparam int unsigned NCOND    = 4;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_t;

    typedef struct packed {
        logic rx_ovf;
        logic rx_ne;
        logic tx_nf;
        logic tx_e;
    } cond_t;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo
    import mbox_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic             empty_o,
    output logic             full_o,
    output logic             drop_o
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PW-1:0]    wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]    cnt_q, cnt_d;
    occ_t             st_q, st_d;
    logic             do_push, do_pop;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push_i && (st_q != OCC_FULL);
    assign do_pop  = pop_i  && (st_q != OCC_EMPTY);

    always_comb begin
        cnt_d = cnt_q;
        if (do_push && !do_pop) begin
            cnt_d = cnt_q + 1'b1;
        end else if (do_pop && !do_push) begin
            cnt_d = cnt_q - 1'b1;
        end
        st_d = st_q;
        unique case (st_q)
            OCC_EMPTY: if (do_push) st_d = OCC_PART;
            OCC_PART: begin
                if (cnt_d == CW'(DEPTH)) begin
                    st_d = OCC_FULL;
                end else if (cnt_d == '0) begin
                    st_d = OCC_EMPTY;
                end
            end
            OCC_FULL:  if (do_pop) st_d = OCC_PART;
            default:   st_d = OCC_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= OCC_EMPTY;
            cnt_q    <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_ptr_q] <= wdata_i;
    end

    always_comb begin
        empty_o = (st_q == OCC_EMPTY);
        full_o  = (st_q == OCC_FULL);
        drop_o  = push_i && (st_q == OCC_FULL);
        rdata_o = mem_q[rd_ptr_q];
    end
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq #(
    parameter int unsigned   N        = 4,
    parameter logic [N-1:0]  COND_RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cond_i,
    input  logic [N-1:0] clr_i,
    input  logic         mask_we_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] req_o,
    output logic [N-1:0] mask_o,
    output logic         irq_o
);
    for (genvar i = 0; i < N; i++) begin : g_src
        logic prev_q;
        logic req_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= COND_RST[i];
                req_q  <= 1'b0;
            end else begin
                prev_q <= cond_i[i];
                // a new rising edge wins over a clear in the same cycle
                req_q  <= (req_q && !clr_i[i]) || (cond_i[i] && !prev_q);
            end
        end
        assign req_o[i] = req_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o <= '0;
        end else if (mask_we_i) begin
            mask_o <= mask_i;
        end
    end

    assign irq_o = |(req_o & mask_o);
endmodule

// File: rtl/mbox_regif.sv
module mbox_regif
    import mbox_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 8,
    parameter int unsigned BYTE_W     = 8,
    parameter int unsigned ADDR_W     = 3,
    parameter int unsigned BUS_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [BYTE_W-1:0] ctl_tx_data,
    output logic              ctl_tx_valid,
    input  logic              ctl_tx_ready,
    input  logic [BYTE_W-1:0] ctl_rx_data,
    input  logic              ctl_rx_valid,
    output logic              ctl_rx_ready,
    output logic              irq_o
);
    localparam int unsigned BYTE_LSB = 8;
    localparam logic [NCOND-1:0] COND_RST = 4'b0011;

    logic              hit_intr, hit_data, hit_stat;
    logic              wr_intr, wr_data, wr_stat, rd_data;
    logic              tx_empty, tx_full, tx_drop;
    logic              rx_empty, rx_full, rx_drop;
    logic [BYTE_W-1:0] rx_head;
    logic              ovf_q;
    cond_t             cond;
    logic [NCOND-1:0]  req_q, mask_q, clr;
    logic              unused_wdata;

    assign hit_intr = bus_sel && (bus_addr == ADDR_W'(REG_INTR));
    assign hit_data = bus_sel && (bus_addr == ADDR_W'(REG_DATA));
    assign hit_stat = bus_sel && (bus_addr == ADDR_W'(REG_STAT));
    assign wr_intr  = hit_intr && bus_wr;
    assign wr_data  = hit_data && bus_wr;
    assign wr_stat  = hit_stat && bus_wr;
    assign rd_data  = hit_data && !bus_wr;
    assign unused_wdata = ^bus_wdata[BUS_W-1:BYTE_LSB+BYTE_W];

    mbox_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .push_i(wr_data), .wdata_i(bus_wdata[BYTE_LSB +: BYTE_W]),
        .pop_i(ctl_tx_ready), .rdata_o(ctl_tx_data),
        .empty_o(tx_empty), .full_o(tx_full), .drop_o(tx_drop)
    );

    mbox_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .push_i(ctl_rx_valid), .wdata_i(ctl_rx_data),
        .pop_i(rd_data), .rdata_o(rx_head),
        .empty_o(rx_empty), .full_o(rx_full), .drop_o(rx_drop)
    );

    assign clr = (wr_intr ? bus_wdata[NCOND-1:0] : '0)
               | (wr_stat ? bus_wdata[NCOND-1:0] : '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= (ovf_q && !(wr_stat && bus_wdata[3])) || rx_drop;
        end
    end

    always_comb begin
        cond.tx_e   = tx_empty;
        cond.tx_nf  = !tx_full;
        cond.rx_ne  = !rx_empty;
        cond.rx_ovf = ovf_q;
    end

    mbox_irq #(.N(NCOND), .COND_RST(COND_RST)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .cond_i(cond), .clr_i(clr),
        .mask_we_i(wr_intr), .mask_i(bus_wdata[2*NCOND-1:NCOND]),
        .req_o(req_q), .mask_o(mask_q), .irq_o(irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (hit_intr) begin
                bus_rdata[2*NCOND-1:0] = {mask_q, req_q};
            end else if (hit_data) begin
                if (!rx_empty) bus_rdata[BYTE_LSB +: BYTE_W] = rx_head;
            end else if (hit_stat) begin
                bus_rdata[NCOND-1:0] = cond;
            end
        end
    end

    assign ctl_tx_valid = !tx_empty;
    assign ctl_rx_ready = !rx_full;
    // tx_drop marks a dropped host write; nothing further is recorded for it
    logic unused_tx_drop;
    assign unused_tx_drop = tx_drop;
endmodule

// File: rtl/mbox_regif_chk.sv
module mbox_regif_chk #(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned BUS_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              ctl_tx_valid,
    input logic              ctl_tx_ready,
    input logic              ctl_rx_valid,
    input logic              ctl_rx_ready,
    input logic              irq_o,
    input logic [3:0]        req_i,
    input logic [3:0]        mask_i,
    input logic              ovf_i,
    input logic              rx_empty_i
);
    logic host_rd, clr_wr;
    assign host_rd = bus_sel && !bus_wr;
    assign clr_wr  = bus_sel && bus_wr &&
                     (bus_addr == ADDR_W'(0) || bus_addr == ADDR_W'(2));

    assert_tx_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(1) && !ctl_tx_ready) |=> ctl_tx_valid);

    assert_rx_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rx_valid && !ctl_rx_ready) |=> ovf_i);

    assert_empty_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && bus_addr == ADDR_W'(1) && rx_empty_i) |-> (bus_rdata == '0));

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && bus_addr >= ADDR_W'(3)) |-> (bus_rdata == '0));

    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == 4'h0) |-> !irq_o);

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((req_i & $past(req_i)) == $past(req_i)));
endmodule

bind mbox_regif mbox_regif_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .ctl_tx_valid(ctl_tx_valid), .ctl_tx_ready(ctl_tx_ready),
    .ctl_rx_valid(ctl_rx_valid), .ctl_rx_ready(ctl_rx_ready),
    .irq_o(irq_o), .req_i(req_q), .mask_i(mask_q), .ovf_i(ovf_q),
    .rx_empty_i(rx_empty)
);

// File: tb/mbox_regif_tb_top.sv
`timescale 1ns/1ps
module mbox_regif_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  ctl_tx_data;
    logic        ctl_tx_valid;
    logic        ctl_tx_ready = 1'b0;
    logic [7:0]  ctl_rx_data = '0;
    logic        ctl_rx_valid = 1'b0;
    logic        ctl_rx_ready;
    logic        irq_o;
    int          n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    mbox_regif dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ctl_tx_data(ctl_tx_data), .ctl_tx_valid(ctl_tx_valid),
        .ctl_tx_ready(ctl_tx_ready), .ctl_rx_data(ctl_rx_data),
        .ctl_rx_valid(ctl_rx_valid), .ctl_rx_ready(ctl_rx_ready),
        .irq_o(irq_o)
    );

    // op: 0 host write, 1 host read and compare, 2 controller push, 3 controller take and compare
    localparam logic [36:0] VEC [18] = '{
        {2'd0, 3'd0, 32'h0000_0044},  // R10 enable receive source
        {2'd2, 3'd0, 32'h0000_00A5},  // R9 push raises rx not empty
        {2'd1, 3'd0, 32'h0000_0044},  // R9 request bit 2 latched
        {2'd1, 3'd2, 32'h0000_0007},  // R3 status bits
        {2'd1, 3'd1, 32'h0000_A500},  // R6 byte in bits 15:8
        {2'd0, 3'd2, 32'h0000_0004},  // R11 acknowledge
        {2'd1, 3'd0, 32'h0000_0040},  // R11 request cleared, mask kept
        {2'd0, 3'd1, 32'h0000_3C00},  // R4
        {2'd0, 3'd1, 32'h0000_1200},  // R4
        {2'd3, 3'd0, 32'h0000_003C},  // R4 order
        {2'd3, 3'd0, 32'h0000_0012},  // R4 order
        {2'd1, 3'd2, 32'h0000_0003},  // R3
        {2'd1, 3'd0, 32'h0000_0041},  // R9 tx empty request
        {2'd0, 3'd5, 32'h0000_00FF},  // R2 reserved write
        {2'd1, 3'd5, 32'h0000_0000},  // R2 reserved reads zero
        {2'd1, 3'd0, 32'h0000_0041},  // R2 reserved write had no effect
        {2'd0, 3'd2, 32'h0000_000F},  // R11 write back all
        {2'd1, 3'd0, 32'h0000_0040}   // R11
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        idle();
    endtask

    task automatic host_rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 check(tag, bus_rdata, exp);
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0;
        idle();
    endtask

    task automatic rx_push(input logic [7:0] b);
        ctl_rx_valid = 1'b1; ctl_rx_data = b;
        @(posedge clk); @(negedge clk);
        ctl_rx_valid = 1'b0;
        idle();
    endtask

    task automatic tx_take(input logic [7:0] exp, input string tag);
        ctl_tx_ready = 1'b1;
        #1 check(tag, {23'd0, ctl_tx_valid, ctl_tx_data}, {23'd0, 1'b1, exp});
        @(posedge clk); @(negedge clk);
        ctl_tx_ready = 1'b0;
        idle();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hang expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R1 reset state
        check("R1 irq", {31'd0, irq_o}, 32'd0);
        check("R1 tx_valid", {31'd0, ctl_tx_valid}, 32'd0);
        check("R1 rx_ready", {31'd0, ctl_rx_ready}, 32'd1);
        host_rd(3'd2, 32'h3, "R1 status");
        host_rd(3'd0, 32'h0, "R1 intr");

        for (int i = 0; i < 18; i++) begin
            logic [1:0]  op;
            logic [2:0]  a;
            logic [31:0] v;
            {op, a, v} = VEC[i];
            case (op)
                2'd0: host_wr(a, v);
                2'd1: host_rd(a, v, $sformatf("table step %0d", i));
                2'd2: rx_push(v[7:0]);
                default: tx_take(v[7:0], $sformatf("table step %0d", i));
            endcase
        end

        // R5 transmit full, ninth write dropped
        for (int i = 0; i < 9; i++) host_wr(3'd1, {16'd0, 8'h10 + 8'(i), 8'd0});
        host_rd(3'd2, 32'h0, "R5 status full");
        for (int i = 0; i < 8; i++) tx_take(8'h10 + 8'(i), "R5 drain");
        check("R5 empty after 8", {31'd0, ctl_tx_valid}, 32'd0);
        host_rd(3'd0, 32'h43, "R9 tx requests");
        check("R10 masked off", {31'd0, irq_o}, 32'd0);
        host_wr(3'd2, 32'h3);

        // R8 receive overflow
        for (int i = 0; i < 8; i++) rx_push(8'h20 + 8'(i));
        check("R8 rx_ready full", {31'd0, ctl_rx_ready}, 32'd0);
        check("R10 irq on", {31'd0, irq_o}, 32'd1);
        rx_push(8'h99);
        host_rd(3'd2, 32'hF, "R8 status overflow");
        for (int i = 0; i < 8; i++) host_rd(3'd1, {16'd0, 8'h20 + 8'(i), 8'd0}, "R6 order");
        host_rd(3'd2, 32'hB, "R8 sticky");
        host_wr(3'd2, 32'h8);
        host_rd(3'd2, 32'h3, "R8 cleared");
        host_rd(3'd0, 32'h44, "R9 hold");
        host_wr(3'd0, 32'h04);
        host_rd(3'd0, 32'h00, "R9 clear via intr");
        check("R10 irq off", {31'd0, irq_o}, 32'd0);
        host_wr(3'd0, 32'h40);

        // R7 empty read
        host_rd(3'd1, 32'h0, "R7 empty read");
        rx_push(8'h5A);
        check("R10 irq on again", {31'd0, irq_o}, 32'd1);
        host_rd(3'd1, 32'h5A00, "R7 next byte");
        host_rd(3'd1, 32'h0, "R7 empty again");
        check("R9 irq latched", {31'd0, irq_o}, 32'd1);
        host_wr(3'd2, 32'h4);
        check("R11 ack drops irq", {31'd0, irq_o}, 32'd0);

        // R1 reset with data in flight
        host_wr(3'd1, 32'h7700);
        rx_push(8'h66);
        rst_n = 1'b0;
        idle(); idle();
        rst_n = 1'b1;
        idle();
        check("R1 tx_valid after reset", {31'd0, ctl_tx_valid}, 32'd0);
        host_rd(3'd2, 32'h3, "R1 status after reset");
        host_rd(3'd0, 32'h0, "R1 intr after reset");

        summary();
        $finish;
    end
endmodule